// File: doc/BRIEF.md
# Resource-Aware Speculative Thread Fetch Selector

This block decides, in every cycle, which of several hardware threads may fetch. Each thread reports whether it is active, how many of its instructions are in flight and whether it runs speculatively. A single flag reports that dependences between threads are present. A count reports how many shared resource slots are free. The output is a grant vector with at most one bit set, and it follows the present inputs and stored history in the same cycle.

Each thread keeps a short history of how many resource slots its last four executions used. That history is written when the thread reports that it has completed. The block takes the worst case in the history as the thread's predicted need. A thread is a candidate only if that need fits into the free resource count. When the dependence flag is up and a fitting non-speculative thread exists, only non-speculative threads compete. Among the competing threads, the one with the fewest instructions in flight wins, and a tie goes to the lowest index.

Top module: `fsel_top`

## Requirements
- R1: After reset every thread's history holds zeros, so its predicted need is 0 and an active thread can be granted even when the free count is 0.
- R2: The grant has at most one bit set, and it never names an inactive thread (thr_active bit 0).
- R3: Among the competing threads, the grant goes to the thread with the smallest in-flight count.
- R4: When several competing threads share the smallest in-flight count, the grant goes to the lowest thread index.
- R5: When dep_flag is 1 and at least one eligible thread has thr_spec bit 0, no thread with thr_spec bit 1 is granted, even if its in-flight count is smaller.
- R6: When dep_flag is 1 and every eligible thread has thr_spec bit 1, the selection falls back to all eligible threads.
- R7: When dep_flag is 0, thr_spec has no effect on the grant.
- R8: A clock edge with done_valid bit i set shifts done_usage slice i into thread i's four-entry history, dropping the oldest sample. The predicted need is the largest of the four stored samples, so a sample stops counting after four newer completions.
- R9: A thread is eligible only if it is active and its predicted need is less than or equal to free_res. Equality counts as a fit.
- R10: When no thread is eligible, the grant is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_active | input | N | Thread i holds a live context |
| thr_icount | input | N*CNT_W | In-flight instruction count per thread; slice i is bits [i*CNT_W +: CNT_W] |
| thr_spec | input | N | 1 marks thread i as speculative |
| dep_flag | input | 1 | Dependences between threads are present |
| free_res | input | RES_W | Number of free shared resource slots |
| done_valid | input | N | Thread i completed an execution in this cycle |
| done_usage | input | N*RES_W | Resource slots used by that execution; slice i is bits [i*RES_W +: RES_W] |
| grant | output | N | Fetch grant, one-hot or zero |

## Verification
The case that is hardest to reach is the one where a thread's predicted need is set by its oldest stored sample. Only the fifth completion of that thread can drop the sample, and only a free count that lies between the old peak and the newer samples shows the change. The stimulus therefore loads one thread with a large sample followed by three small ones, holds the free count between the two values, and checks the grant before and after a fifth completion. The bias under dependences is forced with directed patterns in which the speculative thread has the smallest count, both with and without a fitting non-speculative thread.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    typedef enum logic {
        SEL_ALL     = 1'b0,
        SEL_NONSPEC = 1'b1
    } sel_mode_e;

    function automatic sel_mode_e pick_mode(input logic dep, input logic any_nonspec_fit);
        return (dep && any_nonspec_fit) ? SEL_NONSPEC : SEL_ALL;
    endfunction

endpackage

// File: rtl/fsel_hist.sv
module fsel_hist #(
    parameter int N     = 4,
    parameter int RES_W = 6,
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       done_valid,
    input  logic [N*RES_W-1:0] done_usage,
    output logic [N*RES_W-1:0] need
);
    for (genvar t = 0; t < N; t++) begin : g_thr
        logic [RES_W-1:0] samp [DEPTH];
        logic [RES_W-1:0] peak;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < DEPTH; k++) samp[k] <= '0;
            end else if (done_valid[t]) begin
                samp[0] <= done_usage[t*RES_W +: RES_W];
                for (int k = 1; k < DEPTH; k++) samp[k] <= samp[k-1];
            end
        end

        always_comb begin
            peak = samp[0];
            for (int k = 1; k < DEPTH; k++)
                if (samp[k] > peak) peak = samp[k];
        end

        assign need[t*RES_W +: RES_W] = peak;
    end
endmodule

// File: rtl/fsel_elig.sv
module fsel_elig
    import fsel_pkg::*;
#(
    parameter int N     = 4,
    parameter int RES_W = 6
) (
    input  logic [N-1:0]       thr_active,
    input  logic [N-1:0]       thr_spec,
    input  logic               dep_flag,
    input  logic [RES_W-1:0]   free_res,
    input  logic [N*RES_W-1:0] need,
    output logic [N-1:0]       elig,
    output logic [N-1:0]       cand
);
    sel_mode_e mode;

    for (genvar t = 0; t < N; t++) begin : g_fit
        assign elig[t] = thr_active[t] && (need[t*RES_W +: RES_W] <= free_res);
    end

    assign mode = pick_mode(dep_flag, |(elig & ~thr_spec));
    assign cand = (mode == SEL_NONSPEC) ? (elig & ~thr_spec) : elig;
endmodule

// File: rtl/fsel_arb.sv
module fsel_arb #(
    parameter int N     = 4,
    parameter int CNT_W = 6
) (
    input  logic [N-1:0]       cand,
    input  logic [N*CNT_W-1:0] thr_icount,
    output logic [N-1:0]       grant
);
    logic [CNT_W-1:0] best_cnt;
    logic             found;

    always_comb begin
        grant    = '0;
        best_cnt = '0;
        found    = 1'b0;
        for (int t = 0; t < N; t++) begin
            if (cand[t] && (!found || thr_icount[t*CNT_W +: CNT_W] < best_cnt)) begin
                grant    = '0;
                grant[t] = 1'b1;
                best_cnt = thr_icount[t*CNT_W +: CNT_W];
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsel_top.sv
module fsel_top #(
    parameter int N     = 4,
    parameter int CNT_W = 6,
    parameter int RES_W = 6,
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       thr_active,
    input  logic [N*CNT_W-1:0] thr_icount,
    input  logic [N-1:0]       thr_spec,
    input  logic               dep_flag,
    input  logic [RES_W-1:0]   free_res,
    input  logic [N-1:0]       done_valid,
    input  logic [N*RES_W-1:0] done_usage,
    output logic [N-1:0]       grant
);
    logic [N*RES_W-1:0] need;
    logic [N-1:0]       elig;
    logic [N-1:0]       cand;

    fsel_hist #(.N(N), .RES_W(RES_W), .DEPTH(DEPTH)) hist_i (
        .clk(clk), .rst(rst), .done_valid(done_valid),
        .done_usage(done_usage), .need(need)
    );

    fsel_elig #(.N(N), .RES_W(RES_W)) elig_i (
        .thr_active(thr_active), .thr_spec(thr_spec), .dep_flag(dep_flag),
        .free_res(free_res), .need(need), .elig(elig), .cand(cand)
    );

    fsel_arb #(.N(N), .CNT_W(CNT_W)) arb_i (
        .cand(cand), .thr_icount(thr_icount), .grant(grant)
    );
endmodule

// File: rtl/fsel_chk.sv
module fsel_chk #(
    parameter int N     = 4,
    parameter int CNT_W = 6,
    parameter int RES_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [N-1:0]       thr_active,
    input logic [N*CNT_W-1:0] thr_icount,
    input logic [N-1:0]       thr_spec,
    input logic               dep_flag,
    input logic [RES_W-1:0]   free_res,
    input logic [N-1:0]       done_valid,
    input logic [N*RES_W-1:0] done_usage,
    input logic [N*RES_W-1:0] need,
    input logic [N-1:0]       elig,
    input logic [N-1:0]       cand,
    input logic [N-1:0]       grant
);
    logic [RES_W-1:0] g_need;
    logic [CNT_W-1:0] g_cnt;
    logic             beaten;

    always_comb begin
        g_need = '0;
        g_cnt  = '0;
        for (int t = 0; t < N; t++)
            if (grant[t]) begin
                g_need = need[t*RES_W +: RES_W];
                g_cnt  = thr_icount[t*CNT_W +: CNT_W];
            end
        beaten = 1'b0;
        for (int t = 0; t < N; t++)
            if (cand[t] && thr_icount[t*CNT_W +: CNT_W] < g_cnt) beaten = 1'b1;
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
    a_r2_active: assert property (@(posedge clk) disable iff (rst) (grant & ~thr_active) == '0);
    a_r9_fits:   assert property (@(posedge clk) disable iff (rst) (grant != '0) |-> (g_need <= free_res));
    a_r10_zero:  assert property (@(posedge clk) disable iff (rst) (elig == '0) |-> (grant == '0));
    a_r5_bias:   assert property (@(posedge clk) disable iff (rst)
                     (dep_flag && ((elig & ~thr_spec) != '0)) |-> ((grant & thr_spec) == '0));
    a_r3_min:    assert property (@(posedge clk) disable iff (rst) (grant != '0) |-> !beaten);

    for (genvar t = 0; t < N; t++) begin : g_h
        a_r8_hist: assert property (@(posedge clk) disable iff (rst)
                       done_valid[t] |=> (need[t*RES_W +: RES_W] >= $past(done_usage[t*RES_W +: RES_W])));
    end
endmodule

bind fsel_top fsel_chk #(.N(N), .CNT_W(CNT_W), .RES_W(RES_W)) chk_i (
    .clk(clk), .rst(rst), .thr_active(thr_active), .thr_icount(thr_icount),
    .thr_spec(thr_spec), .dep_flag(dep_flag), .free_res(free_res),
    .done_valid(done_valid), .done_usage(done_usage), .need(need),
    .elig(elig), .cand(cand), .grant(grant)
);

// File: tb/fsel_top_tb_top.sv
`timescale 1ns/1ps
module fsel_top_tb_top;
    localparam int N = 4, CNT_W = 6, RES_W = 6, DEPTH = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic [N-1:0]       thr_active = '0, thr_spec = '0, done_valid = '0;
    logic [N*CNT_W-1:0] thr_icount = '0;
    logic [N*RES_W-1:0] done_usage = '0;
    logic               dep_flag = 1'b0;
    logic [RES_W-1:0]   free_res = '0;
    logic [N-1:0]       grant;

    int n_chk = 0, n_bad = 0;
    int unsigned seed = 32'h5EED_1234;
    logic [RES_W-1:0] mh [N][DEPTH];

    always #2.5 clk = ~clk;

    fsel_top #(.N(N), .CNT_W(CNT_W), .RES_W(RES_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .thr_active(thr_active), .thr_icount(thr_icount),
        .thr_spec(thr_spec), .dep_flag(dep_flag), .free_res(free_res),
        .done_valid(done_valid), .done_usage(done_usage), .grant(grant)
    );

    function automatic logic [RES_W-1:0] m_need(int t);
        logic [RES_W-1:0] p = '0;
        for (int k = 0; k < DEPTH; k++) if (mh[t][k] > p) p = mh[t][k];
        return p;
    endfunction

    function automatic logic [N-1:0] exp_grant();
        logic [N-1:0] el, cd, g;
        logic [CNT_W-1:0] bc;
        int bi;
        for (int t = 0; t < N; t++) el[t] = thr_active[t] && (m_need(t) <= free_res);
        cd = (dep_flag && (el & ~thr_spec) != '0) ? (el & ~thr_spec) : el;
        g = '0; bi = -1; bc = '0;
        for (int t = 0; t < N; t++)
            if (cd[t] && (bi < 0 || thr_icount[t*CNT_W +: CNT_W] < bc)) begin
                bi = t; bc = thr_icount[t*CNT_W +: CNT_W];
            end
        if (bi >= 0) g[bi] = 1'b1;
        return g;
    endfunction

    task automatic check(string tag);
        logic [N-1:0] e = exp_grant();
        n_chk++;
        if (grant !== e) begin
            n_bad++;
            $display("FAIL %s: grant=%b expected=%b", tag, grant, e);
        end
    endtask

    task automatic step(string tag);
        #1 check(tag);
        @(posedge clk);
        for (int t = 0; t < N; t++)
            if (done_valid[t]) begin
                for (int k = DEPTH-1; k > 0; k--) mh[t][k] = mh[t][k-1];
                mh[t][0] = done_usage[t*RES_W +: RES_W];
            end
        @(negedge clk);
        done_valid = '0;
    endtask

    task automatic set_cnt(int a, int b, int c, int d);
        thr_icount = {CNT_W'(d), CNT_W'(c), CNT_W'(b), CNT_W'(a)};
    endtask

    task automatic finish_compl(int t, int u);
        done_valid = '0; done_valid[t] = 1'b1;
        done_usage = '0; done_usage[t*RES_W +: RES_W] = RES_W'(u);
    endtask

    initial begin : watchdog
        #900000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < N; t++) for (int k = 0; k < DEPTH; k++) mh[t][k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: all active, free 0, need 0 after reset
        thr_active = '1; free_res = '0; set_cnt(5, 3, 7, 9);
        step("R1");
        // R3: smallest count wins
        set_cnt(8, 6, 2, 4); free_res = 6'd10;
        step("R3");
        // R4: tie to lowest index
        set_cnt(9, 3, 3, 3);
        step("R4");
        // R2: inactive thread with smallest count not granted
        thr_active = 4'b1110; set_cnt(0, 5, 4, 6);
        step("R2");
        // R10: none active
        thr_active = '0;
        step("R10");
        // R5: dependence bias
        thr_active = '1; thr_spec = 4'b0111; dep_flag = 1'b1; set_cnt(1, 1, 1, 20);
        step("R5");
        // R7: no dependence, spec ignored
        dep_flag = 1'b0;
        step("R7");
        // R8 / R9: thread 3 learns need 10
        finish_compl(3, 10);
        step("R8");
        thr_spec = '0; set_cnt(9, 9, 9, 1); free_res = 6'd9;
        step("R9");           // thread 3 need 10 > 9
        free_res = 6'd10;
        step("R9");           // equality fits
        // R6: only speculative fits under dependence
        thr_spec = 4'b1000; dep_flag = 1'b1; thr_active = 4'b1000;
        step("R6");
        dep_flag = 1'b0; thr_spec = '0; thr_active = '1; free_res = 6'd5;
        // R8: old peak ages out after four newer samples
        for (int i = 0; i < 3; i++) begin finish_compl(3, 1); step("R8"); end
        step("R8");           // still need 10
        finish_compl(3, 2); step("R8");
        step("R8");           // need now 2, thread 3 wins

        // random
        for (int i = 0; i < 3000; i++) begin
            thr_active = N'($urandom(seed) | $urandom(seed));
            thr_spec   = N'($urandom(seed));
            dep_flag   = 1'($urandom(seed));
            free_res   = RES_W'($urandom(seed) % 48);
            for (int t = 0; t < N; t++) thr_icount[t*CNT_W +: CNT_W] = CNT_W'($urandom(seed) % 12);
            done_valid = N'($urandom(seed) & $urandom(seed));
            for (int t = 0; t < N; t++) done_usage[t*RES_W +: RES_W] = RES_W'($urandom(seed) % 50);
            step(i % 2 ? "R5" : "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule